// File: doc/BRIEF.md
# Per-Area External Bus Cycle Controller

This controller sits between a CPU access port and an external memory bus. Each request carries an address, a direction and a size (byte or word). The controller first decides whether the address falls in on-chip space: ROM, RAM, I/O or the peripheral area. If it does not, the controller runs an external bus cycle. The 16 MB space is split into eight 2 MB areas, chosen by address bits [23:21]. Each area has its own data-bus width, its own access length of two or three states, and its own count of extra wait states.

For an external cycle, the controller raises the chip-select of the addressed area and steps through the access states. It drives the read or write strobe from the second state to the last state. On a read, it captures the data at the end of the last state. It then reports completion with a one-cycle done pulse, with the read data alongside. A word access to an area configured for 8 bits runs as two byte cycles. The high byte goes first, at the even address.

Internal hits and area-6 hits raise a one-cycle request on the internal port or the peripheral port instead, and complete on the next cycle. Settings are written through a small configuration port. Settings are taken from the registers at the moment a request is accepted.

Top module: `ext_bus_ctrl`

## Requirements
- R1: The area is `addr[23:21]`. During an external cycle exactly the bit `cs[area]` is high, from the first state through the last state, and `cs` is zero at all other times.
- R2: After reset, every area is a 3-state area with wait field 3, and RAM enable is 1. All width bits are 0 when `bus16_mode` is 1 and 1 when it is 0. `done` and `cs` are low.
- R3: Configuration register 1 (`cfg_sel`=1) holds the state bits, bit n for area n. When bit n is 0, a cycle lasts exactly 2 states whatever the wait field holds.
- R4: Configuration register 2 (`cfg_sel`=2) holds the wait fields, bits [2n+1:2n] for area n. When the state bit is 1, a cycle lasts 3 + W states, where W is 0 to 3.
- R5: Configuration register 0 (`cfg_sel`=0) holds the width bits, bit n for area n, where 0 selects 16-bit and 1 selects 8-bit. A word access to an 8-bit area runs two back-to-back byte cycles: address A carrying the high byte, then A+1 carrying the low byte. `done` follows only the second cycle.
- R6: `ext_rd` (on a read) or `ext_wr` (on a write) is high from state 2 through the last state and never in state 1. Read data is sampled at the end of the last state. A 16-bit word uses `ext_din[15:0]`. A byte uses `ext_din[7:0]` and returns zero in `rdata[15:8]`.
- R7: While `rom_en` is 1, addresses below `ROM_SIZE` are internal. With `rom_en` at 0, all of area 0 is external.
- R8: Addresses from `RAM_LO` to `RAM_HI` are internal only while the RAM-enable bit (`cfg_sel`=3, bit 0) is 1, and are external in area 7 otherwise. Addresses from `IO_LO` to `IO_HI` are always internal.
- R9: Internal hits pulse `int_req`, and other area-6 hits pulse `per_req`, each for one cycle with no chip-select. `done` follows on the next cycle, with `rdata` taken from `int_rdata` or `per_rdata`.
- R10: A configuration write made during an external cycle does not change that cycle. It takes effect from the next access.
- R11: `done` is high for exactly one cycle per accepted request. A request is accepted one clock edge after `req` is seen, and `done` rises L edges after acceptance, where L is the total state count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus16_mode | input | 1 | Reset width selection: 1 gives 16-bit areas, 0 gives 8-bit areas |
| rom_en | input | 1 | On-chip ROM present in area 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 width, 1 states, 2 waits, 3 RAM enable |
| cfg_wdata | input | 16 | Configuration write data |
| req | input | 1 | Access request, sampled while idle |
| addr | input | 24 | Access address |
| wr | input | 1 | 1 for write, 0 for read |
| word | input | 1 | 1 for word, 0 for byte |
| wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| cs | output | 8 | Per-area chip-selects, active high |
| bus_addr | output | 24 | Address of the current cycle |
| ext_rd | output | 1 | External read strobe |
| ext_wr | output | 1 | External write strobe |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| int_req | output | 1 | Internal-space access pulse |
| int_rdata | input | 16 | Internal-space read data |
| per_req | output | 1 | Peripheral-area access pulse |
| per_rdata | input | 16 | Peripheral read data |

## Verification
Most wrong internal state in this block shows up as wrong timing at the ports. A wrong state counter or wait count changes how many cycles a chip-select stays high and how late `done` arrives, so it is visible within the same access. A wrong split or byte-order flag shows as a missing or extra second address on `bus_addr`, or as swapped bytes in `rdata` or `ext_dout`, by the time `done` rises. A decode fault raises the wrong chip-select, or misses `int_req` or `per_req`, within one or two cycles of the request. The bench therefore sweeps every combination of state count, wait count, width, size and direction across five external areas, and compares cycle counts, addresses and data with values worked out from the requirements.

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl #(
  parameter logic [23:0] ROM_SIZE = 24'h010000,
  parameter logic [23:0] RAM_LO   = 24'hFFB000,
  parameter logic [23:0] RAM_HI   = 24'hFFEFFF,
  parameter logic [23:0] IO_LO    = 24'hFFF000,
  parameter logic [23:0] IO_HI    = 24'hFFFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus16_mode,
  input  logic        rom_en,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [15:0] cfg_wdata,
  input  logic        req,
  input  logic [23:0] addr,
  input  logic        wr,
  input  logic        word,
  input  logic [15:0] wdata,
  output logic        done,
  output logic [15:0] rdata,
  output logic [7:0]  cs,
  output logic [23:0] bus_addr,
  output logic        ext_rd,
  output logic        ext_wr,
  output logic [15:0] ext_dout,
  input  logic [15:0] ext_din,
  output logic        int_req,
  input  logic [15:0] int_rdata,
  output logic        per_req,
  input  logic [15:0] per_rdata
);

  logic [7:0]  width_r, ast_r;
  logic [15:0] wait_r;
  logic        ram_en_r;

  logic        busy, split_q, second_q, wr_q, word_q, bus8_q, int_q, per_q;
  logic [2:0]  area_q;
  logic [3:0]  st_q, last_q;
  logic [23:0] addr_q;
  logic [15:0] wdata_q, rdata_q;
  logic        done_q;

  logic [2:0]  area;
  logic        rom_hit, ram_hit, io_hit, is_int, is_per, idle, accept, at_end;
  logic [1:0]  wsel;
  logic [3:0]  last_n;

  assign area    = addr[23:21];
  assign rom_hit = rom_en && (addr < ROM_SIZE);
  assign ram_hit = ram_en_r && (addr >= RAM_LO) && (addr <= RAM_HI);
  assign io_hit  = (addr >= IO_LO) && (addr <= IO_HI);
  assign is_int  = rom_hit || ram_hit || io_hit;
  assign is_per  = (area == 3'd6) && !is_int;
  assign wsel    = wait_r[2*area +: 2];
  assign last_n  = ast_r[area] ? (4'd3 + {2'b00, wsel}) : 4'd2;
  assign idle    = !busy && !int_q && !per_q;
  assign accept  = req && idle;
  assign at_end  = busy && (st_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_r  <= bus16_mode ? 8'h00 : 8'hFF;
      ast_r    <= 8'hFF;
      wait_r   <= 16'hFFFF;
      ram_en_r <= 1'b1;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: width_r  <= cfg_wdata[7:0];
        2'd1: ast_r    <= cfg_wdata[7:0];
        2'd2: wait_r   <= cfg_wdata;
        default: ram_en_r <= cfg_wdata[0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; split_q <= 1'b0; second_q <= 1'b0; wr_q <= 1'b0;
      word_q <= 1'b0; bus8_q <= 1'b0; int_q <= 1'b0; per_q <= 1'b0;
      area_q <= '0; st_q <= '0; last_q <= '0; addr_q <= '0;
      wdata_q <= '0; rdata_q <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      int_q  <= 1'b0;
      per_q  <= 1'b0;
      if (int_q || per_q) begin
        done_q  <= 1'b1;
        rdata_q <= int_q ? int_rdata : per_rdata;
      end
      if (accept) begin
        addr_q  <= addr;
        wr_q    <= wr;
        word_q  <= word;
        wdata_q <= wdata;
        if (is_int) int_q <= 1'b1;
        else if (is_per) per_q <= 1'b1;
        else begin
          busy     <= 1'b1;
          st_q     <= 4'd1;
          last_q   <= last_n;
          area_q   <= area;
          bus8_q   <= width_r[area];
          split_q  <= word && width_r[area];
          second_q <= 1'b0;
        end
      end else if (at_end) begin
        if (split_q && !second_q) begin
          second_q <= 1'b1;
          st_q     <= 4'd1;
          addr_q   <= addr_q + 24'd1;
          if (!wr_q) rdata_q[15:8] <= ext_din[7:0];
        end else begin
          busy   <= 1'b0;
          st_q   <= 4'd0;
          done_q <= 1'b1;
          if (!wr_q) begin
            if (second_q)               rdata_q[7:0] <= ext_din[7:0];
            else if (word_q && !bus8_q) rdata_q <= ext_din;
            else                        rdata_q <= {8'h00, ext_din[7:0]};
          end
        end
      end else if (busy) begin
        st_q <= st_q + 4'd1;
      end
    end
  end

  assign cs       = busy ? (8'd1 << area_q) : 8'd0;
  assign bus_addr = addr_q;
  assign ext_rd   = busy && !wr_q && (st_q >= 4'd2);
  assign ext_wr   = busy &&  wr_q && (st_q >= 4'd2);
  assign ext_dout = split_q ? {8'h00, (second_q ? wdata_q[7:0] : wdata_q[15:8])}
                  : (word_q ? wdata_q : {8'h00, wdata_q[7:0]});
  assign int_req  = int_q;
  assign per_req  = per_q;
  assign done     = done_q;
  assign rdata    = rdata_q;

  // R1
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs));
  // R9
  no_cs_internal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req || per_req) |-> (cs == 8'd0));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R6
  strobe_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd || ext_wr) |-> (cs != 8'd0));
  // R6
  first_state_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|cs) |-> (!ext_rd && !ext_wr));
  // R4
  state_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st_q != 4'd0 && st_q <= last_q && last_q <= 4'd6));
  // R9
  no_double_port_chk: assert property (@(posedge clk) disable iff (!rst_n) !(int_req && per_req));

endmodule

// File: tb/ext_bus_ctrl_tb.sv
module ext_bus_ctrl_tb;
  logic clk = 0, rst_n = 0, bus16_mode = 1, rom_en = 1;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [15:0] cfg_wdata = 0;
  logic req = 0, wr = 0, word = 0; logic [23:0] addr = 0; logic [15:0] wdata = 0;
  logic done, ext_rd, ext_wr, int_req, per_req;
  logic [15:0] rdata, ext_dout, ext_din;
  logic [7:0] cs; logic [23:0] bus_addr;

  always #2.5 clk = ~clk;
  assign ext_din = {~bus_addr[7:0], bus_addr[7:0] + 8'h11};

  ext_bus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus16_mode(bus16_mode), .rom_en(rom_en),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .addr(addr), .wr(wr), .word(word), .wdata(wdata),
    .done(done), .rdata(rdata), .cs(cs), .bus_addr(bus_addr),
    .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_dout(ext_dout), .ext_din(ext_din),
    .int_req(int_req), .int_rdata(16'hC0DE), .per_req(per_req), .per_rdata(16'hBEEF));

  int n_chk = 0, n_fail = 0;
  int lat, cs_cnt, stb_cnt;
  logic cs_bad, int_seen, per_seen, done_twice, aset, dset;
  logic [23:0] a_first, a_last; logic [15:0] d_first, d_last, rd;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic cfg_write(logic [1:0] s, logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk); rst_n = 0; bus16_mode = mode;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic run(logic [23:0] a, logic w, logic wd, logic [15:0] d, logic mid);
    int n;
    lat = 0; cs_cnt = 0; stb_cnt = 0; cs_bad = 0; int_seen = 0; per_seen = 0;
    aset = 0; dset = 0; a_first = 0; a_last = 0; d_first = 0; d_last = 0;
    @(negedge clk); req = 1; addr = a; wr = w; word = wd; wdata = d;
    n = 0;
    do begin
      @(negedge clk); req = 0; n++;
      if (cs != 0) begin
        cs_cnt++;
        if (cs != (8'd1 << a[23:21])) cs_bad = 1;
        if (!aset) begin a_first = bus_addr; aset = 1; end
        a_last = bus_addr;
      end
      if (ext_rd || ext_wr) stb_cnt++;
      if (ext_wr) begin
        if (!dset) begin d_first = ext_dout; dset = 1; end
        d_last = ext_dout;
      end
      int_seen |= int_req; per_seen |= per_req;
      if (mid && n == 2) begin cfg_we = 1; cfg_sel = 2; cfg_wdata = 16'h0000; end
      if (mid && n == 3) cfg_we = 0;
    end while (!done && n < 60);
    lat = n; rd = rdata;
    @(negedge clk); done_twice = done;
  endtask

  task automatic sweep_one(logic [23:0] a, logic w, logic wd, bit ast, int wt, bit w8);
    int L, nc;
    logic [15:0] d, exp_rd;
    L = ast ? 3 + wt : 2;
    nc = (wd && w8) ? 2 : 1;
    d = 16'hA500 ^ a[15:0];
    run(a, w, wd, d, 0);
    check("R11 latency", lat, nc * L + 1);
    check("R11 single pulse", done_twice, 0);
    check(ast ? "R4 cs cycles" : "R3 cs cycles", cs_cnt, nc * L);
    check("R6 strobe cycles", stb_cnt, nc * (L - 1));
    check("R1 cs bit", cs_bad, 0);
    check("R5 first addr", a_first, a);
    check("R5 last addr", a_last, (nc == 2) ? a + 24'd1 : a);
    if (!w) begin
      if (nc == 2) exp_rd = {a[7:0] + 8'h11, a[7:0] + 8'h12};
      else if (wd) exp_rd = {~a[7:0], a[7:0] + 8'h11};
      else exp_rd = {8'h00, a[7:0] + 8'h11};
      check("R6 read data", rd, exp_rd);
    end else if (nc == 2) begin
      check("R5 write high first", d_first, {8'h00, d[15:8]});
      check("R5 write low second", d_last, {8'h00, d[7:0]});
    end else begin
      check("R6 write data", d_first, wd ? d : {8'h00, d[7:0]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R2 reset cs", cs, 0);
    check("R2 reset done", done, 0);
    rst_n = 1;
    // R2: 16-bit mode reset, 3 states + 3 waits
    run(24'h200100, 0, 1, 0, 0);
    check("R2 default latency 16-bit", lat, 7);
    check("R2 default cs", cs_cnt, 6);
    do_reset(0);
    run(24'h400200, 0, 1, 0, 0);
    check("R2 default latency 8-bit split", lat, 13);
    check("R2 default split addr", a_last, 24'h400201);

    for (int ast = 0; ast < 2; ast++)
      for (int wt = 0; wt < 4; wt++)
        for (int w8 = 0; w8 < 2; w8++) begin
          cfg_write(0, w8 ? 16'h00FF : 16'h0000);
          cfg_write(1, ast ? 16'h00FF : 16'h0000);
          cfg_write(2, {8{wt[1:0]}});
          for (int ar = 1; ar < 6; ar++)
            for (int sz = 0; sz < 2; sz++)
              for (int w = 0; w < 2; w++)
                sweep_one({ar[2:0], 21'h001234 + 21'(wt * 2)}, w[0], sz[0], ast[0], wt, w8[0]);
        end

    // R7: ROM hole
    cfg_write(0, 16'h0000); cfg_write(1, 16'h00FF); cfg_write(2, 16'h0000);
    rom_en = 1;
    run(24'h000100, 0, 1, 0, 0);
    check("R7 rom internal", int_seen, 1);
    check("R7 rom no cs", cs_cnt, 0);
    check("R9 internal latency", lat, 2);
    check("R9 internal data", rd, 16'hC0DE);
    run(24'h020000, 0, 1, 0, 0);
    check("R7 above rom external", cs_cnt, 3);
    check("R7 above rom no int", int_seen, 0);
    rom_en = 0;
    run(24'h000100, 0, 1, 0, 0);
    check("R7 rom off external", cs_cnt, 3);
    check("R7 rom off cs0", cs_bad, 0);
    check("R7 rom off data", rd, {8'hFF, 8'h11});

    // R8: RAM hole and I/O
    run(24'hFFC000, 0, 1, 0, 0);
    check("R8 ram internal", int_seen, 1);
    check("R8 ram no cs", cs_cnt, 0);
    cfg_write(3, 16'h0000);
    run(24'hFFC000, 0, 1, 0, 0);
    check("R8 ram off external", cs_cnt, 3);
    check("R8 ram off cs7", cs_bad, 0);
    check("R8 ram off no int", int_seen, 0);
    run(24'hFFF800, 0, 1, 0, 0);
    check("R8 io internal", int_seen, 1);
    check("R8 io no cs", cs_cnt, 0);

    // R9: area 6 peripheral
    run(24'hC00010, 0, 1, 0, 0);
    check("R9 peripheral req", per_seen, 1);
    check("R9 peripheral no cs", cs_cnt, 0);
    check("R9 peripheral data", rd, 16'hBEEF);
    check("R9 peripheral latency", lat, 2);

    // R10: config change mid-cycle
    cfg_write(2, 16'hFFFF);
    run(24'h600300, 0, 1, 0, 1);
    check("R10 current access unchanged", lat, 7);
    run(24'h600300, 0, 1, 0, 0);
    check("R10 next access uses new waits", lat, 4);

    finish_run();
  end
endmodule